// File: doc/BRIEF.md
# Four-Lane Marker Deskew Buffer

This block removes lane-to-lane skew between four lanes that already carry boundary-aligned, decoded code groups. Each code group is nine bits: an eight-bit value plus a flag that marks it as a control character rather than data. Every cycle, each lane writes its incoming group into its own circular buffer. The block then hunts for the alignment character on every lane and notes the buffer address at which each lane first wrote it.

Once all four lanes have produced the alignment character inside a bounded window, the block loads each lane's read pointer with that lane's noted address. Reading then starts on all lanes in the same cycle. From that point the outputs carry the alignment column together, and every later column stays lined up.

An aligned flag shows when the outputs are valid. Only reset or a resync request clears it. A resync restarts the hunt.

Top module: `lane_deskew_buf`

## Requirements
- R1: After reset, and for as long as no alignment has completed, `aligned_o` is 0 and every output lane carries a zero data byte with a zero control flag.
- R2: The alignment character is the group with control flag 1 and value 0x7C. A group with value 0x7C and control flag 0 is treated as ordinary data.
- R3: The hunt starts on the first alignment character seen on any lane. It completes once every lane has produced one. Only the first alignment character of each lane within the hunt counts, and later ones on that lane are ignored.
- R4: Alignment completes for any skew, between the first and the last sighting, of up to DEPTH-3 cycles (13 with the default depth of 16).
- R5: If the hunt has been open for DEPTH-3 cycles without completing, it is abandoned, the captured sightings are discarded and `aligned_o` stays 0. The next alignment character on any lane then opens a new hunt.
- R6: On the second rising clock edge after the cycle that supplies the last lane's alignment character, all four output lanes present the alignment character together, and `aligned_o` rises on that same edge.
- R7: After alignment, output lane l, k cycles after the aligned column, carries the group that lane l received k cycles after its own captured alignment character.
- R8: `resync_i` high at a clock edge clears `aligned_o` and all output lanes to zero and restarts the hunt. Alignment characters present on that cycle are ignored.
- R9: Once aligned, the block stays aligned, with unchanged lane offsets, until reset or resync, whatever alignment characters arrive later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| resync_i | input | 1 | Drop alignment and restart the hunt |
| lane_data_i | input | 32 | Incoming group values, lane l in bits [8l+7:8l] |
| lane_ctrl_i | input | 4 | Incoming control flags, lane l in bit l |
| out_data_o | output | 32 | Deskewed group values, same lane packing |
| out_ctrl_o | output | 4 | Deskewed control flags |
| aligned_o | output | 1 | Outputs are deskewed and valid |

## Verification
The bench aims at the edges of the skew window: 13 cycles must align, while 14 cycles must abandon the hunt and then recover on a later clean set. An off-by-one timer either corrupts a column or never aligns. A lane that repeats the alignment character before the hunt closes exposes a design that re-captures, because its output lane would run two groups late. The bench also drives alignment characters on the resync cycle and a data-flagged 0x7C. A design that honoured either would raise `aligned_o` early. Random skews and payloads then check that every output column matches the per-lane offset model for the whole run.

// File: rtl/deskew_pkg.sv
package deskew_pkg;

  localparam logic [7:0] ALIGN_CHAR = 8'h7C;

  typedef struct packed {
    logic       ctrl;
    logic [7:0] data;
  } cgroup_t;

  typedef enum logic [1:0] {
    ST_SEARCH  = 2'd0,
    ST_COLLECT = 2'd1,
    ST_RUN     = 2'd2
  } dsk_state_e;

  function automatic logic is_align(cgroup_t g);
    return g.ctrl && (g.data == ALIGN_CHAR);
  endfunction

endpackage

// File: rtl/deskew_lane_buf.sv
module deskew_lane_buf
  import deskew_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  cgroup_t grp_i,
  input  logic    cap_i,
  input  logic    load_i,
  input  logic    run_i,
  output logic    marker_o,
  output cgroup_t grp_o
);

  // DEPTH is a power of two; pointers wrap by overflow
  cgroup_t        mem [DEPTH];
  logic [AW-1:0]  wr_ptr_q, rd_ptr_q, mark_addr_q;
  cgroup_t        grp_q;

  assign marker_o = is_align(grp_i);
  assign grp_o    = grp_q;

  always_ff @(posedge clk_i) begin
    mem[wr_ptr_q] <= grp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q    <= '0;
      rd_ptr_q    <= '0;
      mark_addr_q <= '0;
      grp_q       <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + 1'b1;
      if (cap_i) mark_addr_q <= wr_ptr_q;
      // completing lane is captured and loaded in the same cycle
      if (load_i)     rd_ptr_q <= cap_i ? wr_ptr_q : mark_addr_q;
      else if (run_i) rd_ptr_q <= rd_ptr_q + 1'b1;
      grp_q <= run_i ? mem[rd_ptr_q] : '0;
    end
  end

  a_r7_read_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> (rd_ptr_q == AW'($past(rd_ptr_q) + 1'b1)));

  a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(run_i) |-> (grp_q == '0));

endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl
  import deskew_pkg::*;
#(
  parameter int unsigned LANES    = 4,
  parameter int unsigned MAX_SKEW = 13,
  localparam int unsigned TW = $clog2(MAX_SKEW + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             resync_i,
  input  logic [LANES-1:0] marker_i,
  output logic [LANES-1:0] cap_o,
  output logic             load_o,
  output logic             run_o,
  output logic             aligned_o
);

  dsk_state_e       state_q;
  logic [LANES-1:0] seen_q, hits, merged;
  logic [TW-1:0]    timer_q;
  logic             hunting, all_seen, aligned_q;

  assign hunting  = (state_q != ST_RUN);
  assign hits     = hunting ? (marker_i & ~seen_q) : '0;
  assign merged   = seen_q | hits;
  assign all_seen = &merged;
  assign cap_o    = resync_i ? '0 : hits;
  assign load_o   = !resync_i && hunting && (|hits) && all_seen;
  assign run_o    = !resync_i && (state_q == ST_RUN);
  assign aligned_o = aligned_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_SEARCH;
      seen_q    <= '0;
      timer_q   <= '0;
      aligned_q <= 1'b0;
    end else begin
      aligned_q <= run_o;
      if (resync_i) begin
        state_q <= ST_SEARCH;
        seen_q  <= '0;
        timer_q <= '0;
      end else begin
        unique case (state_q)
          ST_SEARCH: begin
            if (|hits) begin
              seen_q <= merged;
              if (all_seen) state_q <= ST_RUN;
              else begin
                state_q <= ST_COLLECT;
                timer_q <= TW'(1);
              end
            end
          end
          ST_COLLECT: begin
            if (all_seen) begin
              seen_q  <= merged;
              state_q <= ST_RUN;
              timer_q <= '0;
            end else if (timer_q == TW'(MAX_SKEW)) begin
              state_q <= ST_SEARCH;
              seen_q  <= '0;
              timer_q <= '0;
            end else begin
              seen_q  <= merged;
              timer_q <= timer_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r5_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timer_q <= TW'(MAX_SKEW));

  a_r3_search_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SEARCH) |-> (seen_q == '0));

  a_r8_resync_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_i |=> (!aligned_o && state_q == ST_SEARCH));

  a_r9_aligned_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aligned_o && !resync_i) |=> aligned_o);

endmodule

// File: rtl/lane_deskew_buf.sv
module lane_deskew_buf
  import deskew_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned LANES    = 4,
  localparam int unsigned MAX_SKEW = DEPTH - 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         resync_i,
  input  logic [31:0]  lane_data_i,
  input  logic [3:0]   lane_ctrl_i,
  output logic [31:0]  out_data_o,
  output logic [3:0]   out_ctrl_o,
  output logic         aligned_o
);

  logic [LANES-1:0] marker, cap, out_mark;
  logic             load, run;
  cgroup_t          lane_in  [LANES];
  cgroup_t          lane_out [LANES];

  deskew_ctrl #(.LANES(LANES), .MAX_SKEW(MAX_SKEW)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .resync_i  (resync_i),
    .marker_i  (marker),
    .cap_o     (cap),
    .load_o    (load),
    .run_o     (run),
    .aligned_o (aligned_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_in[l].ctrl = lane_ctrl_i[l];
    assign lane_in[l].data = lane_data_i[8*l +: 8];

    deskew_lane_buf #(.DEPTH(DEPTH)) u_buf (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .grp_i    (lane_in[l]),
      .cap_i    (cap[l]),
      .load_i   (load),
      .run_i    (run),
      .marker_o (marker[l]),
      .grp_o    (lane_out[l])
    );

    assign out_ctrl_o[l]       = lane_out[l].ctrl;
    assign out_data_o[8*l +: 8] = lane_out[l].data;
    assign out_mark[l]         = is_align(lane_out[l]);
  end

  a_r6_column_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aligned_o && !$past(aligned_o)) |-> (&out_mark));

  a_r1_unaligned_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aligned_o |-> (out_data_o == '0 && out_ctrl_o == '0));

endmodule

// File: tb/lane_deskew_buf_tb.sv
`timescale 1ns/1ps
module lane_deskew_buf_tb;

  localparam int N  = 96;
  localparam int T0 = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        resync = 1'b0;
  logic [31:0] din = '0;
  logic [3:0]  cin = '0;
  logic [31:0] dout;
  logic [3:0]  cout;
  logic        aligned;

  logic [8:0]  strm [4][N];
  int          a_pos [4];
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  lane_deskew_buf u_dut (
    .clk_i(clk), .rst_ni(rst_n), .resync_i(resync),
    .lane_data_i(din), .lane_ctrl_i(cin),
    .out_data_o(dout), .out_ctrl_o(cout), .aligned_o(aligned)
  );

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] rand_grp();
    logic [8:0] g = 9'($urandom);
    if (g[8] && g[7:0] == 8'h7C) g[7:0] = 8'h7D;
    return g;
  endfunction

  task automatic drive_rand();
    for (int l = 0; l < 4; l++) begin
      logic [8:0] g = rand_grp();
      cin[l] = g[8];
      din[8*l +: 8] = g[7:0];
    end
  endtask

  task automatic fill(int o0, int o1, int o2, int o3);
    int off [4];
    off = '{o0, o1, o2, o3};
    for (int l = 0; l < 4; l++) begin
      for (int c = 0; c < N; c++) strm[l][c] = rand_grp();
      a_pos[l] = T0 + off[l];
      strm[l][a_pos[l] - 3] = {1'b0, 8'h7C};   // data-flagged, not a marker (R2)
      strm[l][a_pos[l]]     = {1'b1, 8'h7C};
      strm[l][a_pos[l] + 1] = {1'b1, 8'hBC};
    end
  endtask

  // observe outputs after edge e of the scenario
  task automatic observe(int e, bit ok, int last, string tag);
    logic [35:0] exp_col = '0;
    logic [35:0] act_col;
    logic        exp_al;
    act_col = {cout, dout};
    exp_al  = ok && (e >= last + 1);
    if (exp_al) begin
      for (int l = 0; l < 4; l++) begin
        int idx = a_pos[l] + e - last - 1;
        exp_col[32 + l]    = strm[l][idx][8];
        exp_col[8*l +: 8]  = strm[l][idx][7:0];
      end
    end
    check(aligned == exp_al, {tag, " R6/R9 aligned_o"}, 64'(aligned), 64'(exp_al));
    check(act_col == exp_col, {tag, " R7/R1 column"}, 64'(act_col), 64'(exp_col));
  endtask

  task automatic run_scn(string tag, bit ok, bit a_on_resync);
    int last = 0;
    for (int l = 0; l < 4; l++) if (a_pos[l] > last) last = a_pos[l];
    @(negedge clk);
    resync = 1'b1;
    if (a_on_resync) begin
      cin = 4'hF;
      din = {4{8'h7C}};
    end else drive_rand();
    for (int c = 0; c < N; c++) begin
      @(negedge clk);
      if (c == 0) begin
        resync = 1'b0;
        check(aligned == 1'b0 && cout == '0 && dout == '0, {tag, " R8 resync clears"},
              64'({aligned, cout, dout}), 64'(0));
      end else observe(c - 1, ok, last, tag);
      for (int l = 0; l < 4; l++) begin
        cin[l] = strm[l][c][8];
        din[8*l +: 8] = strm[l][c][7:0];
      end
    end
    @(negedge clk);
    observe(N - 1, ok, last, tag);
    drive_rand();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    drive_rand();
    #1;
    check(aligned == 1'b0 && cout == '0 && dout == '0, "R1 reset state",
          64'({aligned, cout, dout}), 64'(0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      drive_rand();
      check(aligned == 1'b0 && cout == '0, "R1 idle before hunt",
            64'({aligned, cout}), 64'(0));
    end

    // R4 R6 R8: zero skew, markers on the resync cycle ignored
    fill(0, 0, 0, 0);
    run_scn("zero_skew", 1'b1, 1'b1);

    // R4: widest tolerated skew
    fill(0, 5, 13, 2);
    run_scn("max_skew", 1'b1, 1'b0);

    // R5: window of 14 abandoned, later clean set aligns without resync
    fill(30, 31, 32, 33);
    strm[0][2] = {1'b1, 8'h7C};
    for (int l = 1; l < 4; l++) strm[l][16] = {1'b1, 8'h7C};
    run_scn("abandon_r5", 1'b1, 1'b0);

    // R5: window of 14 alone never aligns
    fill(0, 14, 14, 14);
    run_scn("over_skew_r5", 1'b0, 1'b0);

    // R3: repeated marker on lane 1 ignored; R9: late marker after lock
    fill(3, 0, 7, 1);
    strm[1][T0 + 2]  = {1'b1, 8'h7C};
    strm[2][T0 + 40] = {1'b1, 8'h7C};
    run_scn("repeat_r3_r9", 1'b1, 1'b0);

    // R4 R7: random skews within window
    for (int i = 0; i < 8; i++) begin
      fill(int'($urandom % 14), int'($urandom % 14), int'($urandom % 14), int'($urandom % 14));
      run_scn("random_r4", 1'b1, 1'b0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule